// File: doc/BRIEF.md
# Radix-N Nibble Arithmetic Unit

This block carries out 4-bit add-with-carry, subtract-with-borrow, increment and decrement. Each result is corrected to a radix N in the range 1 to 16. N is taken from a 4-bit field of the instruction word. A decoder outside the block supplies the operation, the operand form, the pointer choice (X or Y), a post-increment bit and the radix field. The register file supplies A, B, X, Y and the incoming carry. The block reads one nibble of data memory through the selected pointer. It then returns one write strobe for each destination: B, memory, X or Y, and the carry and zero flags.

Every operation takes two cycles and is driven by a three-state machine. IDLE waits for `start` and, on accepting it, latches the operation and the register values, then moves to FETCH. FETCH is the first cycle. It drives the pointer onto the memory address, reads the nibble when the form needs one, runs the radix adjust and registers the result, then always moves to COMMIT. COMMIT is the second cycle. It asserts exactly one destination write, the flag update and any pointer write-back, then always returns to IDLE. Wider numbers in radix N are handled in software by chaining the memory forms with post-increment. The memory-plus-zero form carries the borrow or carry into the next digit.

Top module: `nib_radix_alu`

## Requirements
- R1: For add (op 00) and increment (op 10) the radix field holds 16−N, so N = 16 − field, and a field of 0 means N = 16.
- R2: For subtract (op 01) and decrement (op 11) the radix field holds N itself, and a field of 0 means N = 16.
- R3: Add computes s = lhs + rhs + C. If s ≥ N, the result is (s − N) mod 16 and carry is 1. Otherwise the result is s mod 16 and carry is 0. Operands by form for add and subtract: form 00 gives lhs=B, rhs=A; form 01 gives lhs=B, rhs=[p]; form 10 gives lhs=[p], rhs=B; form 11 gives lhs=[p], rhs=0.
- R4: Subtract computes d = lhs − rhs − C. If d < 0, the result is (d + N) mod 16 and carry (borrow) is 1. Otherwise the result is d mod 16 and carry is 0.
- R5: Increment and decrement always act on [p] with rhs = 1 and ignore `carry_in` and the form field.
- R6: `zero_out` is 1 exactly when the 4-bit result is 0. `flag_we` is high only in the second cycle.
- R7: `start` is accepted only in IDLE. `busy` is high for the two cycles that follow. The first cycle never writes, and `start` while busy has no effect. A/B/X/Y/carry are sampled in the accepting cycle.
- R8: Add or subtract in forms 00 and 01 write B. All other operations write memory at the address read in the first cycle. Exactly one destination strobe is asserted.
- R9: With post-increment set, a memory form writes pointer+1 (mod 256) back in the second cycle. Form 00 of add or subtract never writes a pointer.
- R10: `use_y`=0 selects X as the pointer and 1 selects Y. `mem_re` is high in the first cycle only for forms that read memory.
- R11: After reset, `busy` and all write and read strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| op_sel | input | 2 | 00 add, 01 subtract, 10 increment, 11 decrement |
| form_sel | input | 2 | Operand form for add and subtract |
| use_y | input | 1 | Pointer select: 0 = X, 1 = Y |
| post_inc | input | 1 | Increment the pointer after the access |
| radix_field | input | 4 | Encoded radix from the instruction word |
| reg_a | input | 4 | Register A |
| reg_b | input | 4 | Register B |
| reg_x | input | 8 | Index register X |
| reg_y | input | 8 | Index register Y |
| carry_in | input | 1 | Current carry flag |
| mem_rdata | input | 4 | Memory read data (combinational) |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 8 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write data |
| b_we | output | 1 | B write strobe |
| b_wdata | output | 4 | B write data |
| x_we | output | 1 | X write strobe |
| x_wdata | output | 8 | New X value |
| y_we | output | 1 | Y write strobe |
| y_wdata | output | 8 | New Y value |
| flag_we | output | 1 | Carry and zero update strobe |
| carry_out | output | 1 | New carry |
| zero_out | output | 1 | New zero |

## Verification
Directed cases put the raw sum or difference exactly on the radix boundary in BCD, binary (field 0) and radix 1. This separates the ≥ comparison from >, and the add encoding of the field from the subtract encoding. Increment and decrement run with carry_in set, to show that the flag is not used. Pointers at 255 show the wrap. A start held through the busy cycles shows that no second operation begins. Random operations, forms, fields and digits, including values at or above N, are compared against a reference model in the bench. Register inputs are scrambled after acceptance to catch operands that are read late rather than latched.

// File: rtl/nib_radix_pkg.sv
package nib_radix_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } nib_op_e;

    typedef enum logic [1:0] {
        FM_B_A    = 2'b00,
        FM_B_MEM  = 2'b01,
        FM_MEM_B  = 2'b10,
        FM_MEM_0  = 2'b11
    } nib_form_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FETCH  = 2'b01,
        ST_COMMIT = 2'b10
    } nib_state_e;

endpackage

// File: rtl/nib_radix_dec.sv
module nib_radix_dec #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] field,
    input  logic             is_add,
    output logic [DIG_W:0]   radix
);
    localparam logic [DIG_W:0] FULL = (DIG_W+1)'(1) << DIG_W;

    always_comb begin
        if (field == '0)
            radix = FULL;
        else if (is_add)
            radix = FULL - {1'b0, field};
        else
            radix = {1'b0, field};
    end
endmodule

// File: rtl/nib_adjust_alu.sv
module nib_adjust_alu #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] lhs,
    input  logic [DIG_W-1:0] rhs,
    input  logic             cin,
    input  logic             is_sub,
    input  logic [DIG_W:0]   radix,
    output logic [DIG_W-1:0] res,
    output logic             cout
);
    localparam int SW = DIG_W + 2;

    logic [SW-1:0] lhs_x, rhs_x, cin_x, rad_x, raw, adj;

    always_comb begin
        lhs_x = SW'(lhs);
        rhs_x = SW'(rhs);
        cin_x = SW'(cin);
        rad_x = SW'(radix);
        if (is_sub) begin
            raw  = lhs_x - rhs_x - cin_x;
            cout = raw[SW-1];
            adj  = cout ? raw + rad_x : raw;
        end else begin
            raw  = lhs_x + rhs_x + cin_x;
            cout = (raw >= rad_x);
            adj  = cout ? raw - rad_x : raw;
        end
        res = adj[DIG_W-1:0];
    end
endmodule

// File: rtl/nib_radix_alu.sv
module nib_radix_alu
    import nib_radix_pkg::*;
#(
    parameter int DIG_W = 4,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       form_sel,
    input  logic             use_y,
    input  logic             post_inc,
    input  logic [DIG_W-1:0] radix_field,
    input  logic [DIG_W-1:0] reg_a,
    input  logic [DIG_W-1:0] reg_b,
    input  logic [PTR_W-1:0] reg_x,
    input  logic [PTR_W-1:0] reg_y,
    input  logic             carry_in,
    input  logic [DIG_W-1:0] mem_rdata,
    output logic             busy,
    output logic [PTR_W-1:0] mem_addr,
    output logic             mem_re,
    output logic             mem_we,
    output logic [DIG_W-1:0] mem_wdata,
    output logic             b_we,
    output logic [DIG_W-1:0] b_wdata,
    output logic             x_we,
    output logic [PTR_W-1:0] x_wdata,
    output logic             y_we,
    output logic [PTR_W-1:0] y_wdata,
    output logic             flag_we,
    output logic             carry_out,
    output logic             zero_out
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [DIG_W-1:0] DIG_ONE = DIG_W'(1);

    nib_state_e       state_q, state_d;
    nib_op_e          op_q;
    nib_form_e        form_q;
    logic [DIG_W-1:0] field_q, a_q, b_q, res_q;
    logic [PTR_W-1:0] ptr_q;
    logic             use_y_q, pinc_q, cin_q, cout_q;

    logic             is_add, reads_mem, writes_b;
    logic [DIG_W-1:0] lhs, rhs, alu_res;
    logic             alu_cin, alu_cout;
    logic [DIG_W:0]   radix;

    assign is_add    = (op_q == OP_ADD) || (op_q == OP_INC);
    assign writes_b  = ((op_q == OP_ADD) || (op_q == OP_SUB)) &&
                       ((form_q == FM_B_A) || (form_q == FM_B_MEM));
    assign reads_mem = !(((op_q == OP_ADD) || (op_q == OP_SUB)) && (form_q == FM_B_A));

    nib_radix_dec #(.DIG_W(DIG_W)) u_dec (
        .field  (field_q),
        .is_add (is_add),
        .radix  (radix)
    );

    always_comb begin
        lhs     = mem_rdata;
        rhs     = DIG_ONE;
        alu_cin = 1'b0;
        if ((op_q == OP_ADD) || (op_q == OP_SUB)) begin
            alu_cin = cin_q;
            unique case (form_q)
                FM_B_A:   begin lhs = b_q;       rhs = a_q;       end
                FM_B_MEM: begin lhs = b_q;       rhs = mem_rdata; end
                FM_MEM_B: begin lhs = mem_rdata; rhs = b_q;       end
                FM_MEM_0: begin lhs = mem_rdata; rhs = '0;        end
            endcase
        end
    end

    nib_adjust_alu #(.DIG_W(DIG_W)) u_alu (
        .lhs    (lhs),
        .rhs    (rhs),
        .cin    (alu_cin),
        .is_sub (!is_add),
        .radix  (radix),
        .res    (alu_res),
        .cout   (alu_cout)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and operand / result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ADD;
            form_q  <= FM_B_A;
            field_q <= '0;
            a_q     <= '0;
            b_q     <= '0;
            ptr_q   <= '0;
            use_y_q <= 1'b0;
            pinc_q  <= 1'b0;
            cin_q   <= 1'b0;
            res_q   <= '0;
            cout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                op_q    <= nib_op_e'(op_sel);
                form_q  <= nib_form_e'(form_sel);
                field_q <= radix_field;
                a_q     <= reg_a;
                b_q     <= reg_b;
                ptr_q   <= use_y ? reg_y : reg_x;
                use_y_q <= use_y;
                pinc_q  <= post_inc;
                cin_q   <= carry_in;
            end
            if (state_q == ST_FETCH) begin
                res_q  <= alu_res;
                cout_q <= alu_cout;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_addr  = ptr_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        b_we      = 1'b0;
        x_we      = 1'b0;
        y_we      = 1'b0;
        flag_we   = 1'b0;
        mem_wdata = res_q;
        b_wdata   = res_q;
        x_wdata   = ptr_q + PTR_ONE;
        y_wdata   = ptr_q + PTR_ONE;
        carry_out = cout_q;
        zero_out  = (res_q == '0);
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  mem_re = reads_mem;
            ST_COMMIT: begin
                flag_we = 1'b1;
                b_we    = writes_b;
                mem_we  = !writes_b;
                x_we    = pinc_q && reads_mem && !use_y_q;
                y_we    = pinc_q && reads_mem && use_y_q;
            end
            default:   ;
        endcase
    end

    // R8
    dest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_we && mem_we));

    // R9
    ptr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_we && y_we));

    // R7
    start_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !flag_we && !b_we && !mem_we));

    // R7
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> !busy);

    // R8
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_re) && $stable(mem_addr)));

    // R6
    flag_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> $past(busy));

endmodule

// File: tb/tb_nib_radix_alu.sv
module tb_nib_radix_alu;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [1:0] op_sel, form_sel;
    logic       use_y, post_inc, carry_in;
    logic [3:0] radix_field, reg_a, reg_b, mem_rdata;
    logic [7:0] reg_x, reg_y;
    logic       busy, mem_re, mem_we, b_we, x_we, y_we, flag_we, carry_out, zero_out;
    logic [7:0] mem_addr, x_wdata, y_wdata;
    logic [3:0] mem_wdata, b_wdata;

    logic [3:0] mem [0:255];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    nib_radix_alu dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .form_sel(form_sel),
        .use_y(use_y), .post_inc(post_inc), .radix_field(radix_field),
        .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y),
        .carry_in(carry_in), .mem_rdata(mem_rdata), .busy(busy), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .b_we(b_we),
        .b_wdata(b_wdata), .x_we(x_we), .x_wdata(x_wdata), .y_we(y_we),
        .y_wdata(y_wdata), .flag_we(flag_we), .carry_out(carry_out), .zero_out(zero_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference radix (R1, R2)
    function automatic int ref_radix(input int op, input int field);
        if (field == 0) return 16;
        if (op == 0 || op == 2) return 16 - field;
        return field;
    endfunction

    // reference result: {carry, res} (R3, R4, R5)
    function automatic int ref_calc(input int op, input int form, input int a, input int b,
                                    input int m, input int cin, input int field);
        int n, l, r, c, v;
        n = ref_radix(op, field);
        c = cin;
        if (op >= 2) begin l = m; r = 1; c = 0; end
        else case (form)
            0: begin l = b; r = a; end
            1: begin l = b; r = m; end
            2: begin l = m; r = b; end
            default: begin l = m; r = 0; end
        endcase
        if (op == 0 || op == 2) begin
            v = l + r + c;
            if (v >= n) return 16 | ((v - n) & 15);
            return v & 15;
        end
        v = l - r - c;
        if (v < 0) return 16 | ((v + n) & 15);
        return v & 15;
    endfunction

    task automatic run_op(input int op, input int form, input int field, input bit uy,
                          input bit pinc, input int a, input int b, input int x, input int y,
                          input bit cin, input bit hold, input string tag);
        int ptr, m, e, er, ec;
        bit to_b, rd;
        ptr = uy ? y : x;
        m   = mem[ptr];
        e   = ref_calc(op, form, a, b, m, cin, field);
        er  = e & 15;
        ec  = (e >> 4) & 1;
        to_b = (op < 2) && (form < 2);
        rd   = !((op < 2) && (form == 0));
        @(negedge clk);
        start = 1'b1; op_sel = 2'(op); form_sel = 2'(form); radix_field = 4'(field);
        use_y = uy; post_inc = pinc; reg_a = 4'(a); reg_b = 4'(b);
        reg_x = 8'(x); reg_y = 8'(y); carry_in = cin;
        @(negedge clk);
        start = hold;
        reg_a = 4'($urandom); reg_b = 4'($urandom); carry_in = 1'($urandom);
        reg_x = 8'($urandom); reg_y = 8'($urandom);
        chk({"R7 busy first ", tag}, busy, 1);
        chk({"R7 no flag first ", tag}, flag_we, 0);
        chk({"R10 mem_re ", tag}, mem_re, rd);
        chk({"R10 addr ", tag}, mem_addr, ptr);
        @(negedge clk);
        chk({"R6 flag_we ", tag}, flag_we, 1);
        chk({"R8 b_we ", tag}, b_we, to_b);
        chk({"R8 mem_we ", tag}, mem_we, !to_b);
        if (to_b) chk({"R3/R4 b_wdata ", tag}, b_wdata, er);
        else begin
            chk({"R3/R4 mem_wdata ", tag}, mem_wdata, er);
            chk({"R8 wr addr ", tag}, mem_addr, ptr);
            mem[mem_addr] = mem_wdata;
        end
        chk({"R3/R4 carry ", tag}, carry_out, ec);
        chk({"R6 zero ", tag}, zero_out, er == 0);
        chk({"R9 x_we ", tag}, x_we, pinc && rd && !uy);
        chk({"R9 y_we ", tag}, y_we, pinc && rd && uy);
        if (pinc && rd) chk({"R9 ptr next ", tag}, uy ? y_wdata : x_wdata, (ptr + 1) & 255);
        @(negedge clk);
        start = 1'b0;
        chk({"R7 idle after ", tag}, busy, 0);
        chk({"R7 no extra commit ", tag}, flag_we, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        for (int i = 0; i < 256; i++) mem[i] = 4'(i * 7 + 3);
        rst_n = 1'b0; start = 1'b0; op_sel = '0; form_sel = '0; use_y = 0; post_inc = 0;
        radix_field = '0; reg_a = '0; reg_b = '0; reg_x = '0; reg_y = '0; carry_in = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 strobes", {mem_re, mem_we, b_we, x_we, y_we, flag_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 add, field 0 -> N=16: 15+0+1 = 16 -> 0, carry
        run_op(0, 0, 0, 0, 0, 0, 15, 0, 0, 1, 0, "R1 n16");
        // R1 BCD (field 6 -> N=10): 9+1 = 10 exactly on boundary
        run_op(0, 0, 6, 0, 0, 1, 9, 0, 0, 0, 0, "R1 bcd edge");
        // R3 below boundary: 5+3+0 = 8
        run_op(0, 0, 6, 0, 0, 3, 5, 0, 0, 0, 0, "R3 below");
        // R1 N=1 (field 15): 0+0 -> 0, no carry
        mem[8'h10] = 4'd0;
        run_op(0, 3, 15, 0, 0, 0, 0, 8'h10, 0, 0, 0, "R1 n1");
        // R2 sub N=10: 3-5 = -2 -> 8, borrow
        run_op(1, 0, 10, 0, 0, 5, 3, 0, 0, 0, 0, "R2 bcd");
        // R2 sub field 0 -> N=16: 0-0-1 -> 15
        run_op(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R2 n16");
        // R4 difference exactly 0
        run_op(1, 0, 10, 0, 0, 7, 7, 0, 0, 0, 0, "R4 zero");
        // R5 increment ignores carry: 9+1 radix 10 -> 0
        mem[8'h20] = 4'd9;
        run_op(2, 1, 6, 0, 1, 0, 0, 8'h20, 0, 1, 0, "R5 inc");
        // R5 decrement ignores carry: 0-1 radix 10 -> 9, Y pointer
        mem[8'h30] = 4'd0;
        run_op(3, 0, 10, 1, 1, 0, 0, 0, 8'h30, 1, 0, "R5 dec");
        // R9 pointer wrap on X and Y
        run_op(0, 3, 6, 0, 1, 0, 0, 255, 0, 1, 0, "R9 xwrap");
        run_op(1, 2, 10, 1, 1, 0, 4, 0, 255, 0, 0, "R9 ywrap");
        // R9 register form with post_inc: no pointer write
        run_op(0, 0, 6, 0, 1, 2, 2, 5, 5, 0, 0, "R9 regform");
        // R10 Y selected, B <- B + [Y]
        run_op(0, 1, 0, 1, 0, 0, 6, 1, 8'h44, 0, 0, "R10 ysel");
        // R7 start held through busy cycles
        run_op(0, 2, 6, 0, 0, 0, 3, 8'h50, 0, 1, 1, "R7 hold");

        for (int i = 0; i < 300; i++) begin
            run_op(int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(15)),
                   1'($urandom), 1'($urandom), int'($urandom_range(15)),
                   int'($urandom_range(15)), int'($urandom_range(255)),
                   int'($urandom_range(255)), 1'($urandom), 1'($urandom), "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule